// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for each beat of a four-beat memory burst. A load strobe captures a full starting address. After that, each advance steps through the burst. The upper address bits stay as loaded. The two low bits are produced internally from the loaded low bits and a beat counter.

A static order select picks between two sequences:

- **Linear:** the low bits count upward and wrap within the aligned group of four words.
- **Interleaved:** the low bits are the loaded low bits XORed with the beat count.

Holding the advance input inactive makes a wait cycle, which freezes the address. The full current address and the beat index both come from registers.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `addr_o` is 0 and `beat_o` is 0.
- R2: A rising edge with `load_i` high makes `addr_o` equal to `start_addr_i` and `beat_o` equal to 0 after that edge.
- R3: With `mode_i` = 0 (linear), each advance adds one to the low two bits of `addr_o`, modulo 4 (start 01 gives 01, 10, 11, 00).
- R4: With `mode_i` = 1 (interleaved), on beat k the low two bits of `addr_o` equal the loaded low bits XOR k (start 01 gives 01, 00, 11, 10; start 10 gives 10, 11, 00, 01).
- R5: Between loads, the bits of `addr_o` above the low two never change.
- R6: A rising edge with `load_i` low and `adv_n_i` high (a wait cycle) leaves `addr_o` and `beat_o` unchanged.
- R7: When `load_i` is high and `adv_n_i` is low at the same edge, the load wins: the new address is taken and `beat_o` is 0.
- R8: An advance from beat 3 returns `beat_o` to 0 and `addr_o` to the loaded address. Further advances repeat the same group of four.
- R9: A load in the middle of a burst restarts the sequence from the new address at beat 0.
- R10: `beat_o` is 1 more than its previous value, modulo 4, after each edge with `load_i` low and `adv_n_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Captures `start_addr_i` and clears the beat counter |
| start_addr_i | input | AW (16) | Full starting word address |
| adv_n_i | input | 1 | Active-low advance; high means a wait cycle |
| mode_i | input | 1 | Static order select: 0 linear, 1 interleaved |
| addr_o | output | AW (16) | Registered current word address |
| beat_o | output | 2 | Registered beat index within the burst |

## Verification
The bench goes after start addresses whose low bits are not 00. With such a start, an interleaved design that used linear counting would give 10 instead of 00 on the second beat of a start at 01, and a linear design that failed to wrap would carry into bit 2.

It also targets several other faults:
- a load and an advance in the same cycle, where a wrong priority would show beat 1;
- long wait runs, which expose any drift;
- a fifth advance, where a design that stopped would stick at beat 3;
- a reload in the middle of a burst, where a counter that was not cleared would keep its old beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv_n,
  output logic [BEAT_W-1:0] cnt_q,
  output logic [BEAT_W-1:0] cnt_nxt
);

  localparam logic [BEAT_W-1:0] ONE  = BEAT_W'(1);
  localparam logic [BEAT_W-1:0] LAST = {BEAT_W{1'b1}};

  always_comb begin
    if (load)        cnt_nxt = '0;
    else if (!adv_n) cnt_nxt = cnt_q + ONE;
    else             cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  // R8
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST && !load && !adv_n) |=> (cnt_q == '0));

  // R10
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n) |=> (cnt_q == $past(cnt_q) + ONE));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_low,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] low
);

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  assign lin_low = start_low + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_low[b] = start_low[b] ^ beat[b];
  end

  always_comb begin
    low = ilv_low;
    if (order == ORD_LINEAR) low = lin_low;
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int AW     = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [AW-1:0]     start_addr_i,
  input  logic              adv_n_i,
  input  logic              mode_i,
  output logic [AW-1:0]     addr_o,
  output logic [BEAT_W-1:0] beat_o
);

  localparam int HI_W = AW - BEAT_W;

  logic [AW-1:0]     base_q;
  logic [AW-1:0]     base_nxt;
  logic [BEAT_W-1:0] cnt_nxt;
  logic [BEAT_W-1:0] low_nxt;
  logic [AW-1:0]     addr_q;
  order_e            order;

  assign order    = order_e'(mode_i);
  assign base_nxt = load_i ? start_addr_i : base_q;

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .load    (load_i),
    .adv_n   (adv_n_i),
    .cnt_q   (beat_o),
    .cnt_nxt (cnt_nxt)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_low (base_nxt[BEAT_W-1:0]),
    .beat      (cnt_nxt),
    .order     (order),
    .low       (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      addr_q <= '0;
    end else begin
      base_q <= base_nxt;
      addr_q <= {base_nxt[AW-1:BEAT_W], low_nxt};
    end
  end

  assign addr_o = addr_q;

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (addr_o == $past(start_addr_i) && beat_o == '0));

  // R5
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(addr_o[AW-1:BEAT_W]));

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_n_i) |=> ($stable(addr_o) && $stable(beat_o)));

  // R4
  ilv_relation_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && mode_i && $past(mode_i)) |=>
      ((addr_o[BEAT_W-1:0] ^ beat_o) ==
       ($past(addr_o[BEAT_W-1:0]) ^ $past(beat_o))));

  // R3
  lin_relation_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !mode_i && !$past(mode_i)) |=>
      (BEAT_W'(addr_o[BEAT_W-1:0] - beat_o) ==
       BEAT_W'($past(addr_o[BEAT_W-1:0]) - $past(beat_o))));

  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && !adv_n_i) |=> (beat_o == '0));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && beat_o == '0));

endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          load_i;
  logic [AW-1:0] start_addr_i;
  logic          adv_n_i;
  logic          mode_i;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [AW-1:0] exp_start;
  logic [1:0]    exp_beat;

  always #5 clk = ~clk;

  burst_addr_gen #(.AW(AW), .BEAT_W(2)) uut (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load_i),
    .start_addr_i (start_addr_i),
    .adv_n_i      (adv_n_i),
    .mode_i       (mode_i),
    .addr_o       (addr_o),
    .beat_o       (beat_o)
  );

  function automatic logic [AW-1:0] model_addr(logic [AW-1:0] s, logic [1:0] k, logic m);
    logic [1:0] lo;
    lo = m ? (s[1:0] ^ k) : 2'(s[1:0] + k);
    return {s[AW-1:2], lo};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic cyc(logic ld, logic [AW-1:0] a, logic advn);
    load_i       = ld;
    start_addr_i = a;
    adv_n_i      = advn;
    @(negedge clk);
    if (ld) begin
      exp_start = a;
      exp_beat  = 2'd0;
    end else if (!advn) begin
      exp_beat = exp_beat + 2'd1;
    end
    load_i  = 1'b0;
    adv_n_i = 1'b1;
  endtask

  task automatic chk_state(string tag);
    chk({tag, " addr"}, 32'(addr_o), 32'(model_addr(exp_start, exp_beat, mode_i)));
    chk({tag, " beat"}, 32'(beat_o), 32'(exp_beat));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cyc(1'b0, '0, 1'b1);
    cyc(1'b0, '0, 1'b1);
    exp_start = '0;
    exp_beat  = '0;
    chk("R1 reset addr", 32'(addr_o), 32'h0);
    chk("R1 reset beat", 32'(beat_o), 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_linear;
    mode_i = 1'b0;
    cyc(1'b1, 16'h1231, 1'b1);
    chk("R2 load linear", 32'(addr_o), 32'h1231);
    cyc(1'b0, '0, 1'b0); chk("R3 lin beat1", 32'(addr_o), 32'h1232);
    cyc(1'b0, '0, 1'b0); chk("R3 lin beat2", 32'(addr_o), 32'h1233);
    cyc(1'b0, '0, 1'b0); chk("R3 R5 lin beat3 no carry", 32'(addr_o), 32'h1230);
    chk("R10 lin beat idx", 32'(beat_o), 32'd3);
  endtask

  task automatic t_interleave;
    mode_i = 1'b1;
    cyc(1'b1, 16'hABC5, 1'b1);
    chk("R2 load ilv", 32'(addr_o), 32'hABC5);
    cyc(1'b0, '0, 1'b0); chk("R4 ilv01 beat1", 32'(addr_o), 32'hABC4);
    cyc(1'b0, '0, 1'b0); chk("R4 ilv01 beat2", 32'(addr_o), 32'hABC7);
    cyc(1'b0, '0, 1'b0); chk("R4 ilv01 beat3", 32'(addr_o), 32'hABC6);
    cyc(1'b1, 16'h0F0A, 1'b1);
    cyc(1'b0, '0, 1'b0); chk("R4 ilv10 beat1", 32'(addr_o), 32'h0F0B);
    cyc(1'b0, '0, 1'b0); chk("R4 ilv10 beat2", 32'(addr_o), 32'h0F08);
    cyc(1'b0, '0, 1'b0); chk("R4 ilv10 beat3", 32'(addr_o), 32'h0F09);
  endtask

  task automatic t_wait;
    mode_i = 1'b0;
    cyc(1'b1, 16'h7FFE, 1'b1);
    cyc(1'b0, '0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 16'hFFFF, 1'b1);
      chk_state("R6 wait hold");
    end
    chk("R6 R5 wait addr", 32'(addr_o), 32'h7FFF);
    cyc(1'b0, '0, 1'b0);
    chk("R3 R5 after wait wraps low", 32'(addr_o), 32'h7FFC);
  endtask

  task automatic t_priority;
    mode_i = 1'b1;
    cyc(1'b1, 16'h0100, 1'b1);
    cyc(1'b0, '0, 1'b0);
    cyc(1'b1, 16'h2222, 1'b0);
    chk("R7 load wins addr", 32'(addr_o), 32'h2222);
    chk("R7 load wins beat", 32'(beat_o), 32'd0);
  endtask

  task automatic t_wrap;
    for (int m = 0; m < 2; m++) begin
      mode_i = m[0];
      cyc(1'b1, 16'h4443, 1'b1);
      for (int i = 0; i < 9; i++) begin
        cyc(1'b0, '0, 1'b0);
        chk_state("R8 wrap");
      end
      chk("R8 wrap back beat", 32'(beat_o), 32'd1);
    end
  endtask

  task automatic t_reload;
    mode_i = 1'b0;
    cyc(1'b1, 16'h1110, 1'b1);
    cyc(1'b0, '0, 1'b0);
    cyc(1'b0, '0, 1'b0);
    cyc(1'b1, 16'h9993, 1'b1);
    chk("R9 reload addr", 32'(addr_o), 32'h9993);
    chk("R9 reload beat", 32'(beat_o), 32'd0);
    cyc(1'b0, '0, 1'b0);
    chk("R9 R3 reload next", 32'(addr_o), 32'h9990);
  endtask

  task automatic t_reset_mid;
    cyc(1'b1, 16'h5555, 1'b1);
    cyc(1'b0, '0, 1'b0);
    rst = 1'b1;
    cyc(1'b0, '0, 1'b0);
    chk("R1 mid reset addr", 32'(addr_o), 32'h0);
    chk("R1 mid reset beat", 32'(beat_o), 32'h0);
    rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; load_i = 1'b0; start_addr_i = '0; adv_n_i = 1'b1; mode_i = 1'b0;
    exp_start = '0; exp_beat = '0;
    @(negedge clk);
    t_reset();
    t_linear();
    t_interleave();
    t_wait();
    t_priority();
    t_wrap();
    t_reload();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule